// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor core that finishes every instruction in one clock period. It fetches a word from an internal instruction store at the program counter, decodes it, reads up to two of its 32 general registers, runs the arithmetic unit, and optionally reads or writes an internal data store. All of these steps happen in the same period. It supports nine instructions: register add, subtract, AND, OR and signed set-less-than, word load and word store with a signed 16-bit displacement, branch-if-equal, and absolute jump.

The core is built from two parts under a thin top. A control unit decodes the 6-bit opcode and the function field into a small struct of strobes. A datapath holds the program counter, the two address adders, the sign extender, the register file, the ALU and both word-addressed stores. Every state element changes on the falling clock edge. Before releasing reset, a loader port fills either store one word at a time. A debug port reads any data-store word without a clock.

Top module: `sc_core`

## Requirements
- R1: While `rstN` is low the PC reads 0, and reset forces it there at once without waiting for a clock edge; when reset ends all 32 registers hold zero.
- R2: An instruction that is neither a taken branch nor a jump leaves the PC at its old value plus 4.
- R3: Opcode 0x00 selects a register operation by function code: 0x20 add, 0x22 subtract (rs minus rt), 0x24 AND, 0x25 OR, 0x2A set-less-than (1 when rs is less than rt as signed numbers, else 0). The result goes to the register in bits 15:11.
- R4: Opcode 0x23 loads the data word at rs plus the sign-extended bits 15:0 into the register in bits 20:16. Negative displacements are allowed.
- R5: Opcode 0x2B stores register rt (bits 20:16) to the data word at rs plus the sign-extended displacement and writes no register.
- R6: Opcode 0x04 compares rs with rt. When they are equal the PC becomes PC+4 plus the sign-extended displacement shifted left by two. Otherwise it becomes PC+4.
- R7: Opcode 0x02 sets the PC to the top 4 bits of PC+4, followed by the 26-bit target field, followed by two zero bits. A target of 26 gives 104. Instructions in between are skipped.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: Any other opcode, or a register operation with an unlisted function code, changes no register and no data word and advances the PC by 4.
- R10: The PC, the registers and the data store change only on the falling clock edge; they hold through the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset of PC and registers |
| progWe | input | 1 | Loader write strobe, taken on the falling edge |
| progSel | input | 1 | Loader target: 0 instruction store, 1 data store |
| progAddr | input | 6 | Loader word index |
| progData | input | 32 | Loader word value |
| dbgAddr | input | 6 | Data-store word index for the debug read |
| dbgData | output | 32 | Data-store word at `dbgAddr`, combinational |
| pcOut | output | 32 | Current program counter (byte address) |

## Verification
The assertions assume that stores are loaded only while reset is held, and that the program keeps every fetch and data address word-aligned and inside the 64-word stores. They also assume that each word fetched is one of the decoded formats or a deliberately unknown opcode. The stimulus keeps to these limits: the test programs use aligned displacements and small positive bases. They end in a branch to itself, so the PC never walks past loaded words. Decode corners are covered by an unknown opcode whose fields would look like a store or load if it were misdecoded. Reset corners are covered by reloading a fresh program after a run that left registers non-zero.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN      = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_AW    = $clog2(REG_COUNT);

  // major opcodes, bits 31:26
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JMP   = 6'h02;

  // function codes, bits 5:0 of register operations
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_NONE  = 2'b11
  } aluOp_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluCtl_e;

  typedef struct packed {
    logic    regDst;
    logic    aluSrc;
    logic    memToReg;
    logic    regWrite;
    logic    memRead;
    logic    memWrite;
    logic    branch;
    logic    jump;
    aluOp_e  aluOp;
    aluCtl_e aluCtl;
  } ctrl_t;

endpackage

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  logic    functOk;
  aluCtl_e fnCtl;

  // function-field refinement for register operations
  always_comb begin
    functOk = 1'b1;
    case (funct)
      FN_ADD:  fnCtl = ALU_ADD;
      FN_SUB:  fnCtl = ALU_SUB;
      FN_AND:  fnCtl = ALU_AND;
      FN_OR:   fnCtl = ALU_OR;
      FN_SLT:  fnCtl = ALU_SLT;
      default: begin
        fnCtl   = ALU_ADD;
        functOk = 1'b0;
      end
    endcase
  end

  // main decode, then ALU decode from the 2-bit class
  always_comb begin
    ctrl        = '0;
    ctrl.aluOp  = AOP_NONE;
    ctrl.aluCtl = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.regDst   = 1'b1;
        ctrl.regWrite = functOk;
        ctrl.aluOp    = AOP_FUNCT;
      end
      OP_LW: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.memRead  = 1'b1;
        ctrl.aluOp    = AOP_ADD;
      end
      OP_SW: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
        ctrl.aluOp    = AOP_ADD;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = AOP_SUB;
      end
      OP_JMP: begin
        ctrl.jump = 1'b1;
      end
      default: ;
    endcase
    case (ctrl.aluOp)
      AOP_SUB:   ctrl.aluCtl = ALU_SUB;
      AOP_FUNCT: ctrl.aluCtl = fnCtl;
      default:   ctrl.aluCtl = ALU_ADD;
    endcase
  end

  // R5/R9: a single instruction never writes both a register and a data word
  always_comb begin
    assert_write_exclusive_R5: assert ($onehot0({ctrl.regWrite, ctrl.memWrite}))
      else $error("register and memory write strobes both raised");
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic [REG_AW-1:0] rdAddrB,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [XLEN-1:0]   wrData
);

  logic [XLEN-1:0] regs [REG_COUNT];

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

  // R8: the zero register never yields a non-zero value
  assert_r0_read_R8: assert property (@(negedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0))
    else $error("register 0 read non-zero");

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluCtl_e         aluCtl,
  output logic [XLEN-1:0] result,
  output logic            zero
);

  logic [XLEN-1:0] diff;

  assign diff = opA - opB;

  always_comb begin
    case (aluCtl)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SUB: result = diff;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = opA + opB;
    endcase
  end

  assign zero = (result == '0);

  // R3: set-less-than yields only 0 or 1
  always_comb begin
    if (aluCtl == ALU_SLT) begin
      assert_slt_bool_R3: assert (result[XLEN-1:1] == '0)
        else $error("set-less-than result wider than one bit");
    end
  end

endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter  int MEM_WORDS = 64,
  localparam int AW        = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrl,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  input  logic            progWe,
  input  logic            progSel,
  input  logic [AW-1:0]   progAddr,
  input  logic [XLEN-1:0] progData,
  input  logic [AW-1:0]   dbgAddr,
  output logic [XLEN-1:0] dbgData,
  output logic [XLEN-1:0] pcOut
);

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  logic [XLEN-1:0]   pc, pcNext, pcPlus4, brTarget, jTarget;
  logic [XLEN-1:0]   instr, immExt;
  logic [XLEN-1:0]   rdA, rdB, aluB, aluY, memRdData, wrData;
  logic [REG_AW-1:0] wrReg;
  logic              aluZero, takeBranch;
  logic              unusedBits;

  // fetch
  assign instr  = imem[pc[AW+1:2]];
  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  // immediate and next-PC arithmetic
  assign immExt     = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign pcPlus4    = pc + XLEN'(4);
  assign brTarget   = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jTarget    = {pcPlus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};
  assign takeBranch = ctrl.branch && aluZero;

  always_comb begin
    if (ctrl.jump)       pcNext = jTarget;
    else if (takeBranch) pcNext = brTarget;
    else                 pcNext = pcPlus4;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) pc <= '0;
    else       pc <= pcNext;
  end

  sc_regfile regfile_i (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddrA (instr[25:21]),
    .rdAddrB (instr[20:16]),
    .rdDataA (rdA),
    .rdDataB (rdB),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (wrReg),
    .wrData  (wrData)
  );

  assign wrReg = ctrl.regDst ? instr[15:11] : instr[20:16];
  assign aluB  = ctrl.aluSrc ? immExt : rdB;

  sc_alu alu_i (
    .opA    (rdA),
    .opB    (aluB),
    .aluCtl (ctrl.aluCtl),
    .result (aluY),
    .zero   (aluZero)
  );

  // data store
  assign memRdData = ctrl.memRead ? dmem[aluY[AW+1:2]] : '0;
  assign wrData    = ctrl.memToReg ? memRdData : aluY;
  assign dbgData   = dmem[dbgAddr];

  always_ff @(negedge clk) begin
    if (progWe && !progSel) imem[progAddr] <= progData;
  end

  always_ff @(negedge clk) begin
    if (progWe && progSel)          dmem[progAddr] <= progData;
    else if (rstN && ctrl.memWrite) dmem[aluY[AW+1:2]] <= rdB;
  end

  assign pcOut      = pc;
  assign unusedBits = ^{instr[10:6], aluY[XLEN-1:AW+2], aluY[1:0], ctrl.aluOp};

  // R2: plain instructions step the PC by one word
  assert_pc_step_R2: assert property (@(negedge clk) disable iff (!rstN)
    (!ctrl.jump && !takeBranch) |=> (pc == $past(pc) + XLEN'(4)))
    else $error("PC did not advance by 4");

  // R6: a taken branch lands on PC+4 plus the scaled displacement
  assert_branch_target_R6: assert property (@(negedge clk) disable iff (!rstN)
    (ctrl.branch && aluZero) |=>
      (pc == $past(pc) + XLEN'(4) + {$past(immExt[XLEN-3:0]), 2'b00}))
    else $error("taken branch went to wrong address");

  // R7: jump keeps the upper nibble and places the target field
  assert_jump_target_R7: assert property (@(negedge clk) disable iff (!rstN)
    ctrl.jump |=> (pc[27:2] == $past(instr[25:0])) && (pc[1:0] == 2'b00) &&
                  (pc[31:28] == $past(pcPlus4[31:28])))
    else $error("jump went to wrong address");

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter  int MEM_WORDS = 64,
  localparam int AW        = $clog2(MEM_WORDS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            progWe,
  input  logic            progSel,
  input  logic [AW-1:0]   progAddr,
  input  logic [XLEN-1:0] progData,
  input  logic [AW-1:0]   dbgAddr,
  output logic [XLEN-1:0] dbgData,
  output logic [XLEN-1:0] pcOut
);

  ctrl_t      ctrl;
  logic [5:0] opcode;
  logic [5:0] funct;

  sc_control control_i (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  sc_datapath #(.MEM_WORDS(MEM_WORDS)) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .opcode   (opcode),
    .funct    (funct),
    .progWe   (progWe),
    .progSel  (progSel),
    .progAddr (progAddr),
    .progData (progData),
    .dbgAddr  (dbgAddr),
    .dbgData  (dbgData),
    .pcOut    (pcOut)
  );

endmodule

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

  localparam int PERIOD = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        progWe = 1'b0;
  logic        progSel = 1'b0;
  logic [5:0]  progAddr = '0;
  logic [31:0] progData = '0;
  logic [5:0]  dbgAddr = '0;
  logic [31:0] dbgData;
  logic [31:0] pcOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sc_core dut_i (
    .clk(clk), .rstN(rstN), .progWe(progWe), .progSel(progSel),
    .progAddr(progAddr), .progData(progData), .dbgAddr(dbgAddr),
    .dbgData(dbgData), .pcOut(pcOut)
  );

  // expected PC per cycle after reset release (R2, R6, R7)
  localparam logic [31:0] EXP_PC [25] = '{
    32'd0,  32'd4,  32'd8,  32'd12, 32'd16, 32'd20, 32'd24, 32'd28,
    32'd32, 32'd36, 32'd40, 32'd44, 32'd48, 32'd52, 32'd56, 32'd60,
    32'd64, 32'd68, 32'd80, 32'd84, 32'd88, 32'd92, 32'd104, 32'd108,
    32'd108
  };

  // expected data words after the first program
  localparam int NCHK = 12;
  localparam logic [5:0]  CHK_ADDR [NCHK] = '{6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9,
                                               6'd10, 6'd11, 6'd12, 6'd13, 6'd14, 6'd0};
  localparam logic [31:0] CHK_VAL  [NCHK] = '{32'd4, 32'd10, 32'd4, 32'hFFFF_FFFF,
                                               32'd1, 32'd0, 32'd0, 32'h5555_5555,
                                               32'hFFFF_FFFD, 32'h5555_5555, 32'd8, 32'd7};

  function automatic string chkReq(int idx);
    case (idx)
      0, 1, 2, 3, 4, 5: return "R3";
      6:                return "R8";
      7:                return "R6";
      8:                return "R4";
      9, 10:            return "R7";
      default:          return "R5";
    endcase
  endfunction

  function automatic logic [31:0] rType(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] iType(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadWord(logic sel, int addr, logic [31:0] data);
    @(posedge clk);
    progWe   = 1'b1;
    progSel  = sel;
    progAddr = 6'(addr);
    progData = data;
  endtask

  task automatic readData(int addr, output logic [31:0] val);
    dbgAddr = 6'(addr);
    #1;
    val = dbgData;
  endtask

  logic [31:0] prog [28];

  initial begin
    logic [31:0] rd;
    prog[0]  = iType(6'h23, 0, 1, 0);        // lw  r1, 0(r0)
    prog[1]  = iType(6'h23, 0, 2, 4);        // lw  r2, 4(r0)
    prog[2]  = rType(1, 2, 3, 6'h20);        // add r3
    prog[3]  = rType(1, 2, 4, 6'h22);        // sub r4
    prog[4]  = rType(2, 3, 5, 6'h24);        // and r5
    prog[5]  = rType(2, 1, 6, 6'h25);        // or  r6
    prog[6]  = rType(2, 1, 7, 6'h2A);        // slt r7 = 1
    prog[7]  = rType(1, 2, 8, 6'h2A);        // slt r8 = 0
    prog[8]  = rType(1, 1, 0, 6'h20);        // add into r0
    prog[9]  = iType(6'h2B, 0, 3, 16);
    prog[10] = iType(6'h2B, 0, 4, 20);
    prog[11] = iType(6'h2B, 0, 5, 24);
    prog[12] = iType(6'h2B, 0, 6, 28);
    prog[13] = iType(6'h2B, 0, 7, 32);
    prog[14] = iType(6'h2B, 0, 8, 36);
    prog[15] = iType(6'h2B, 0, 0, 40);
    prog[16] = iType(6'h04, 1, 2, 5);        // beq not taken
    prog[17] = iType(6'h04, 1, 1, 2);        // beq taken to word 20
    prog[18] = iType(6'h2B, 0, 1, 44);
    prog[19] = iType(6'h2B, 0, 1, 44);
    prog[20] = rType(3, 3, 10, 6'h20);       // r10 = 8
    prog[21] = iType(6'h23, 10, 9, -4);      // lw r9, -4(r10)
    prog[22] = iType(6'h2B, 0, 9, 48);
    prog[23] = {6'h02, 26'd26};              // j 104
    prog[24] = iType(6'h2B, 0, 1, 52);
    prog[25] = iType(6'h2B, 0, 1, 52);
    prog[26] = iType(6'h2B, 0, 10, 56);
    prog[27] = iType(6'h04, 0, 0, -1);       // spin

    for (int i = 0; i < 28; i++) loadWord(1'b0, i, prog[i]);
    loadWord(1'b1, 0, 32'd7);
    loadWord(1'b1, 1, 32'hFFFF_FFFD);
    loadWord(1'b1, 2, 32'h1234_5678);
    loadWord(1'b1, 10, 32'hDEAD_0000);
    loadWord(1'b1, 11, 32'h5555_5555);
    loadWord(1'b1, 13, 32'h5555_5555);
    loadWord(1'b1, 15, 32'hA5A5_A5A5);
    @(posedge clk);
    progWe = 1'b0;
    #1 check(pcOut, 32'd0, "R1 PC held at 0 in reset");

    @(posedge clk);
    rstN = 1'b1;
    #1 check(pcOut, EXP_PC[0], "R1 PC after reset");
    for (int i = 1; i < 25; i++) begin
      @(posedge clk);
      #1 check(pcOut, EXP_PC[i], "R2/R6/R7 PC sequence");
      if (i == 3) begin
        #2 check(pcOut, EXP_PC[3], "R10 PC holds before falling edge");
        @(negedge clk);
        #1 check(pcOut, EXP_PC[4], "R10 PC changes at falling edge");
      end
    end

    for (int k = 0; k < NCHK; k++) begin
      readData(int'(CHK_ADDR[k]), rd);
      check(rd, CHK_VAL[k], chkReq(k));
    end

    // second phase: asynchronous reset, fresh program, unknown opcode
    #1 rstN = 1'b0;
    #1 check(pcOut, 32'd0, "R1 asynchronous reset");
    loadWord(1'b0, 0, {6'h3F, 5'd1, 5'd1, 16'd60});   // unknown opcode
    loadWord(1'b0, 1, iType(6'h2B, 0, 1, 56));         // sw r1, 56(r0)
    loadWord(1'b0, 2, iType(6'h04, 0, 0, -1));
    @(posedge clk);
    progWe = 1'b0;
    @(posedge clk);
    rstN = 1'b1;
    #1 check(pcOut, 32'd0, "R9 PC start");
    @(posedge clk);
    #1 check(pcOut, 32'd4, "R9 unknown opcode advances PC");
    @(posedge clk);
    #1 check(pcOut, 32'd8, "R2 PC after store");
    @(posedge clk);
    #1 check(pcOut, 32'd8, "R6 self branch");
    readData(15, rd);
    check(rd, 32'hA5A5_A5A5, "R9 unknown opcode wrote no data");
    readData(14, rd);
    check(rd, 32'd0, "R1 registers cleared by reset");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule